// File: doc/BRIEF.md
# Cold/Warm Global Reset Controller

This block produces the chip-level resets from a set of reset sources and sorts every event into one of two classes. It drives two active-low outputs. The functional reset goes to all logic. The power-on reset goes only to state that must survive a quick recovery, such as PLL settings, memory controller setup and control registers. A cold event asserts both outputs. A warm event asserts only the functional reset, so power-on-class state keeps its contents.

The sources are the power-on pin, an external warm pin, a watchdog expiry pulse, emulation cold and warm request pulses, and a two-bit software control register. The two pins are asynchronous and are synchronized inside the block. The pulses are synchronous to `clk_i`. Both outputs stay asserted for a hold window of `HOLD_CYC` cycles, and this window is never shorter than 16. A sticky cause register records which sources have fired. Its contents, and those of the control register, are cleared only by the power-on pin, so software can read the cause after any other reset.

The register port has two locations. Address 0 is the control register: bit 1 requests a cold reset and bit 0 requests a warm reset. Address 1 is the read-only cause register. Its bits are: 0 power-on, 1 software cold, 2 emulation cold, 3 software warm, 4 watchdog, 5 external pin, 6 emulation warm. Read data is combinational from the address.

Top module: `rstgen_top`

## Requirements
- R1: While `por_n_i` is low, both outputs are low, and they go low asynchronously when the pin falls. After the pin rises, both outputs are low for exactly H+1 sampled cycles, where H = `HOLD_CYC`. The cause register then reads 0x01, and any earlier bits are cleared.
- R2: A cold request drives both outputs low for exactly H cycles after the edge that samples it. The cold requests are a `emu_cold_i` pulse or a control-register write with bit 1 set (written value 0x2).
- R3: A warm request drives only `func_rst_n_o` low, for exactly H cycles, and `pwron_rst_n_o` stays high. The warm requests are a `wdt_expire_i` pulse, a `emu_warm_i` pulse or a control write of 0x1. Logic reset only by `pwron_rst_n_o` keeps its value.
- R4: A low level on `ext_warm_n_i` pulls `func_rst_n_o` low asynchronously and leaves `pwron_rst_n_o` high. `func_rst_n_o` returns high after the synchronized pin release plus the hold window. Cause bit 5 is set.
- R5: When a cold request and a warm request occur in the same cycle, the cold pattern is produced. Only the cold cause bit is set by that cycle.
- R6: A warm request during a warm hold restarts the window. A cold request during a warm hold upgrades the event to cold and restarts the window. A warm request during a cold hold neither extends nor downgrades it.
- R7: Control-register request bits clear one cycle after they are written, so address 0 reads 0 once the sequence has begun.
- R8: Cause bits are sticky. They accumulate across warm and non-power-on cold events and keep their positions as listed above. Writes to address 1 are ignored.
- R9: The control and cause registers are not reset by either reset output. Only the power-on pin clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset pin, active low, asynchronous |
| ext_warm_n_i | input | 1 | External warm reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous |
| emu_cold_i | input | 1 | Emulation cold request pulse, synchronous |
| emu_warm_i | input | 1 | Emulation warm request pulse, synchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 cause |
| reg_wdata_i | input | 2 | Write data: bit 1 cold request, bit 0 warm request |
| reg_rdata_o | output | 7 | Read data of the selected register |
| func_rst_n_o | output | 1 | Functional (warm-class) reset, active low |
| pwron_rst_n_o | output | 1 | Power-on-class reset, active low |

## Verification
The assertions assume that the watchdog, emulation and register inputs are synchronous to the clock. They also assume that `por_n_i` is low from time zero, and every property is disabled while it stays low. The stimulus changes synchronous inputs only on falling edges, and each request is one cycle wide. The two pins are moved away from rising edges, so the asynchronous paths can be observed a moment after the pin moves.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  localparam int CAUSE_W = 7;
  localparam int CTRL_W  = 2;

  // cause register bit positions (software decodes these)
  localparam int CB_POR      = 0;
  localparam int CB_SW_COLD  = 1;
  localparam int CB_EMU_COLD = 2;
  localparam int CB_SW_WARM  = 3;
  localparam int CB_WDT      = 4;
  localparam int CB_EXT      = 5;
  localparam int CB_EMU_WARM = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WARM = 2'd1,
    SEQ_COLD = 2'd2
  } seq_state_e;

  // hold window actually used: never below 16 cycles
  function automatic int hold_cycles(input int requested);
    return (requested < 16) ? 16 : requested;
  endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic sync_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_arb.sv
module rstgen_arb
  import rstgen_pkg::*;
(
  input  logic [1:0]         cold_vec_i,  // {emu, sw}
  input  logic [3:0]         warm_vec_i,  // {emu, ext, wdt, sw}
  output logic               cold_req_o,
  output logic               warm_req_o,
  output logic [CAUSE_W-1:0] set_cause_o
);
  logic [3:0] warm_kept;

  assign cold_req_o = |cold_vec_i;
  assign warm_req_o = |warm_vec_i;
  // cold wins: warm causes of the same cycle are not recorded
  assign warm_kept  = warm_vec_i & {4{~cold_req_o}};

  always_comb begin
    set_cause_o              = '0;
    set_cause_o[CB_SW_COLD]  = cold_vec_i[0];
    set_cause_o[CB_EMU_COLD] = cold_vec_i[1];
    set_cause_o[CB_SW_WARM]  = warm_kept[0];
    set_cause_o[CB_WDT]      = warm_kept[1];
    set_cause_o[CB_EXT]      = warm_kept[2];
    set_cause_o[CB_EMU_WARM] = warm_kept[3];
  end
endmodule

// File: rtl/rstgen_seq.sv
module rstgen_seq
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic cold_req_i,
  input  logic warm_req_i,
  output logic func_n_o,
  output logic pwron_n_o
);
  localparam int HOLD_EFF = hold_cycles(HOLD_CYC);
  localparam int CNT_W    = $clog2(HOLD_EFF);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_EFF - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SEQ_COLD;
      cnt_q   <= '0;
    end else if (cold_req_i) begin
      state_q <= SEQ_COLD;
      cnt_q   <= '0;
    end else if (warm_req_i && state_q != SEQ_COLD) begin
      state_q <= SEQ_WARM;
      cnt_q   <= '0;
    end else if (state_q != SEQ_IDLE) begin
      if (cnt_q == CNT_LAST) begin
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign func_n_o  = (state_q == SEQ_IDLE);
  assign pwron_n_o = (state_q != SEQ_COLD);
endmodule

// File: rtl/rstgen_regs.sv
module rstgen_regs
  import rstgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               ctrl_wr_i,
  input  logic               addr_i,
  input  logic [CTRL_W-1:0]  wdata_i,
  input  logic [CAUSE_W-1:0] set_cause_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [CAUSE_W-1:0] status_o,
  output logic [CAUSE_W-1:0] rdata_o
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [CAUSE_W-1:0] status_q;

  // request bits live one cycle: the sequence starts on the next edge
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= wdata_i;
    else                ctrl_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) status_q <= CAUSE_W'(1) << CB_POR;
    else          status_q <= status_q | set_cause_i;
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
  assign rdata_o  = addr_i ? status_q : CAUSE_W'(ctrl_q);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               por_n_i,
  input  logic               ext_warm_n_i,
  input  logic               wdt_expire_i,
  input  logic               emu_cold_i,
  input  logic               emu_warm_i,
  input  logic               reg_wr_i,
  input  logic               reg_addr_i,
  input  logic [CTRL_W-1:0]  reg_wdata_i,
  output logic [CAUSE_W-1:0] reg_rdata_o,
  output logic               func_rst_n_o,
  output logic               pwron_rst_n_o
);
  logic               por_sync_n;
  logic               ext_arst_n;
  logic               ext_sync_n;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               ctrl_wr;
  logic               cold_req;
  logic               warm_req;
  logic [CAUSE_W-1:0] set_cause;
  logic [CAUSE_W-1:0] status_q;
  logic               func_q;
  logic               pwron_q;

  rstgen_sync #(.STAGES(SYNC_STAGES)) por_sync_i (
    .clk_i(clk_i), .arst_n_i(por_n_i), .sync_n_o(por_sync_n)
  );

  assign ext_arst_n = ext_warm_n_i & por_n_i;

  rstgen_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
    .clk_i(clk_i), .arst_n_i(ext_arst_n), .sync_n_o(ext_sync_n)
  );

  assign ctrl_wr = reg_wr_i & ~reg_addr_i;

  rstgen_arb arb_i (
    .cold_vec_i  ({emu_cold_i, ctrl_q[1]}),
    .warm_vec_i  ({emu_warm_i, ~ext_sync_n, wdt_expire_i, ctrl_q[0]}),
    .cold_req_o  (cold_req),
    .warm_req_o  (warm_req),
    .set_cause_o (set_cause)
  );

  rstgen_seq #(.HOLD_CYC(HOLD_CYC)) seq_i (
    .clk_i      (clk_i),
    .rst_n_i    (por_sync_n),
    .cold_req_i (cold_req),
    .warm_req_i (warm_req),
    .func_n_o   (func_q),
    .pwron_n_o  (pwron_q)
  );

  rstgen_regs regs_i (
    .clk_i       (clk_i),
    .rst_n_i     (por_sync_n),
    .ctrl_wr_i   (ctrl_wr),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .set_cause_i (set_cause),
    .ctrl_o      (ctrl_q),
    .status_o    (status_q),
    .rdata_o     (reg_rdata_o)
  );

  // the external pin reaches the functional output without waiting a clock
  assign func_rst_n_o  = func_q & ext_sync_n;
  assign pwron_rst_n_o = pwron_q;
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       func_rst_n_o,
  input logic       pwron_rst_n_o,
  input logic       cold_req,
  input logic       warm_req,
  input logic       ctrl_wr,
  input logic [1:0] ctrl_q,
  input logic [6:0] status_q
);
  // R1
  pwron_implies_func_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !pwron_rst_n_o |-> !func_rst_n_o);

  // R2
  cold_global_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cold_req |=> (!pwron_rst_n_o && !func_rst_n_o));

  // R3
  warm_keeps_pwron_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (warm_req && !cold_req && pwron_rst_n_o) |=> (!func_rst_n_o && pwron_rst_n_o));

  // R7
  ctrl_selfclear_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (ctrl_q != 2'b00 && !ctrl_wr) |=> (ctrl_q == 2'b00));

  // R8
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (status_q != 7'd0) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

bind rstgen_top rstgen_chk chk_i (
  .clk_i         (clk_i),
  .por_n_i       (por_n_i),
  .func_rst_n_o  (func_rst_n_o),
  .pwron_rst_n_o (pwron_rst_n_o),
  .cold_req      (cold_req),
  .warm_req      (warm_req),
  .ctrl_wr       (ctrl_wr),
  .ctrl_q        (ctrl_q),
  .status_q      (status_q)
);

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_n = 1'b1;
  logic       wdt = 1'b0;
  logic       emu_cold = 1'b0;
  logic       emu_warm = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [1:0] reg_wdata = 2'b00;
  logic [6:0] rdata;
  logic       func_n;
  logic       pwr_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nf = 0;
  int np = 0;
  logic cnt_en = 1'b0;
  logic load = 1'b0;
  logic [7:0] keep_q;
  logic [7:0] fun_q;
  logic [6:0] exp_status;

  always #4 clk = ~clk;

  rstgen_top #(.HOLD_CYC(H)) dut_i (
    .clk_i(clk), .por_n_i(por_n), .ext_warm_n_i(ext_n), .wdt_expire_i(wdt),
    .emu_cold_i(emu_cold), .emu_warm_i(emu_warm), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .func_rst_n_o(func_n), .pwron_rst_n_o(pwr_n)
  );

  // downstream models: one kept across warm resets, one not
  always_ff @(posedge clk or negedge pwr_n)
    if (!pwr_n) keep_q <= 8'h00; else if (load) keep_q <= 8'hA5;
  always_ff @(posedge clk or negedge func_n)
    if (!func_n) fun_q <= 8'h00; else if (load) fun_q <= 8'h3C;

  // {source[2:0], cold, cause[6:0]}
  localparam logic [10:0] VEC [8] = '{
    {3'd5, 1'b1, 7'h02},  // R5 sw write 0x3
    {3'd6, 1'b1, 7'h04},  // R5 emu cold + emu warm
    {3'd7, 1'b1, 7'h04},  // R5 emu cold + watchdog
    {3'd0, 1'b0, 7'h10},  // R3 watchdog
    {3'd1, 1'b0, 7'h40},  // R3 emu warm
    {3'd2, 1'b1, 7'h04},  // R2 emu cold
    {3'd3, 1'b0, 7'h08},  // R3 sw write 0x1
    {3'd4, 1'b1, 7'h02}   // R2 sw write 0x2
  };

  always begin
    @(posedge clk);
    #2;
    if (cnt_en) begin
      if (!func_n) nf++;
      if (!pwr_n) np++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic drive_src(input int src, input logic on);
    case (src)
      0: wdt = on;
      1: emu_warm = on;
      2: emu_cold = on;
      3, 4, 5: begin
        reg_wr = on; reg_addr = 1'b0;
        reg_wdata = on ? 2'(src - 2) : 2'b00;
      end
      6: begin emu_cold = on; emu_warm = on; end
      default: begin emu_cold = on; wdt = on; end
    endcase
  endtask

  task automatic pulse_load();
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
  endtask

  task automatic pair(input int a, input int b);
    @(negedge clk);
    nf = 0; np = 0; cnt_en = 1'b1;
    drive_src(a, 1'b1);
    @(negedge clk) drive_src(a, 1'b0);
    repeat (4) @(negedge clk);
    drive_src(b, 1'b1);
    @(negedge clk) drive_src(b, 1'b0);
    repeat (45) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    // R1 power-on
    @(negedge clk);
    chk("R1 func low in POR", int'(func_n), 0);
    chk("R1 pwron low in POR", int'(pwr_n), 0);
    repeat (2) @(negedge clk);
    por_n = 1'b1; nf = 0; np = 0; cnt_en = 1'b1;
    repeat (40) @(negedge clk);
    cnt_en = 1'b0;
    chk("R1 func hold after POR", nf, H + 1);
    chk("R1 pwron hold after POR", np, H + 1);
    rd(1'b1, v); chk("R1 cause after POR", v, 1);
    exp_status = 7'h01;

    // table of single events
    for (int i = 0; i < 8; i++) begin
      pulse_load();
      @(negedge clk);
      nf = 0; np = 0; cnt_en = 1'b1;
      drive_src(int'(VEC[i][10:8]), 1'b1);
      @(negedge clk) drive_src(int'(VEC[i][10:8]), 1'b0);
      repeat (40) @(negedge clk);
      cnt_en = 1'b0;
      exp_status = exp_status | VEC[i][6:0];
      chk($sformatf("R2/R3 func hold vec%0d", i), nf, H);
      chk($sformatf("R2/R3 pwron hold vec%0d", i), np, VEC[i][7] ? H : 0);
      chk($sformatf("R3 retained state vec%0d", i), int'(keep_q), VEC[i][7] ? 0 : 8'hA5);
      chk($sformatf("R3 functional state vec%0d", i), int'(fun_q), 0);
      rd(1'b1, v); chk($sformatf("R5/R8/R9 cause vec%0d", i), v, int'(exp_status));
      rd(1'b0, v); chk($sformatf("R7 ctrl cleared vec%0d", i), v, 0);
    end

    // R4 external pin
    @(negedge clk);
    nf = 0; np = 0; cnt_en = 1'b1;
    ext_n = 1'b0;
    #1;
    chk("R4 func async low", int'(func_n), 0);
    chk("R4 pwron high", int'(pwr_n), 1);
    repeat (5) @(negedge clk);
    ext_n = 1'b1;
    repeat (40) @(negedge clk);
    cnt_en = 1'b0;
    chk("R4 func released", int'(func_n), 1);
    chk("R4 pwron never low", np, 0);
    exp_status = exp_status | 7'h20;
    rd(1'b1, v); chk("R4 cause bit 5", v, int'(exp_status));

    // R6 overlapping events
    pair(0, 0);
    chk("R6 warm restarts func", nf, H + 5);
    chk("R6 warm restarts pwron", np, 0);
    pair(0, 2);
    chk("R6 upgrade func", nf, H + 5);
    chk("R6 upgrade pwron", np, H);
    pair(2, 0);
    chk("R6 cold not extended func", nf, H);
    chk("R6 cold not extended pwron", np, H);

    // R8 cause register ignores writes
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 2'b00;
    @(negedge clk) reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 write ignored func", int'(func_n), 1);
    rd(1'b1, v); chk("R8 write ignored cause", v, int'(exp_status));

    // R1 later power-on clears history, asynchronous assertion
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R1 async func", int'(func_n), 0);
    chk("R1 async pwron", int'(pwr_n), 0);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 released", int'(pwr_n & func_n), 1);
    rd(1'b1, v); chk("R1 cause cleared", v, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule